// File: doc/BRIEF.md
# Dual Comparator Control and Status Register File

This block is the software-visible register file of a two-channel comparator peripheral. It sits on a simple single-cycle bus with 32-bit data and byte offsets. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is a combinational function of `bus_addr` and the current register state. Six word locations are implemented: one control word per channel, a shared status word, a reference-setting word, a calibration control word and a read-only calibration status word.

Each channel's control word is decoded into plain configuration pins that drive that channel's filter and edge unit. The status word combines three kinds of bits. Event flags (interrupt and wake-up) are set by hardware pulses and cleared by software writing 1. Live output and state bits are forced to 0 while their channel is disabled. A window-compare result is derived from both channels. The block has no streaming data path, so every pin is a plain level or pulse with no handshake.

Top module: `dcmp_csr`

## Requirements
- R1: The word offsets are 0x00 for channel 0 control, 0x04 for channel 1 control, 0x08 for status, 0x0C for reference, 0x10 for calibration control and 0x14 for calibration status. Any other offset, including any offset that is not a multiple of 4, reads 0 and ignores writes.
- R2: In a control word, bit 0 is enable, bit 1 is interrupt enable, bit 3 is invert, [5:4] is the negative-input select, [7:6] is the positive-input select, [9:8] is the edge polarity, bit 12 is the output select, [15:13] is the filter length code, bit 16 is the wake-up enable, bit 17 is the window latch and bit 18 is the window mode. Each field appears on the matching `ch_*` pin slice for that channel (channel i uses slice i).
- R3: Control bits outside the mask 0x0007F3FB read 0, and writing 1 to them has no effect.
- R4: After reset every register reads 0 and every output pin is 0.
- R5: Status bit i (i = 0, 1) is channel i's interrupt flag. A pulse on `edge_evt[i]` sets it while channel i is enabled. `irq[i]` equals the flag ANDed with that channel's interrupt enable.
- R6: Writing status with bit i = 1 clears the matching flag, and writing 0 leaves it unchanged. If a set event and a clearing write fall in the same cycle, the flag ends up set.
- R7: Status bit 8+i is channel i's wake-up flag. It is set by `wake_evt[i]` while channel i is enabled and its wake-up enable is 1, and it is cleared by writing 1 to that bit. `wake_irq[i]` equals the flag ANDed with the interrupt enable.
- R8: Status bits 4+i show `cmp_out[i]` and bits 12+i show `cmp_state[i]`. Each of these bits reads 0 while channel i is disabled, and writes do not affect them.
- R9: Status bit 16 is 1 exactly when channel 0's window mode bit is set, status bit 4 reads 1 and status bit 5 reads 0.
- R10: The reference word holds a 4-bit level at [3:0] and a source select at bit 6. All other bits read 0. The fields drive `ref_level` and `ref_src`.
- R11: The calibration control word holds per-channel triggers at bits 0 and 1, clock selects at [5:4] and [7:6], and reverse bits at 16 and 17. All other bits read 0. The fields drive `cal_trig`, `cal_clk_sel` and `cal_rev`.
- R12: The calibration status word reads {pos1, neg1, done1} at [6:4] and {pos0, neg0, done0} at [2:0] from the `cal_*` inputs, with all other bits 0. Writes to offset 0x14 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| cmp_out | input | 2 | Synchronized channel outputs |
| cmp_state | input | 2 | Synchronized channel state |
| edge_evt | input | 2 | Edge-detected event pulses |
| wake_evt | input | 2 | Wake-up event pulses |
| cal_done | input | 2 | Calibration done per channel |
| cal_neg | input | 2 | Calibration negative status per channel |
| cal_pos | input | 2 | Calibration positive status per channel |
| ch_enable | output | 2 | Channel enable |
| ch_irq_en | output | 2 | Interrupt enable |
| ch_invert | output | 2 | Output invert |
| ch_neg_sel | output | 4 | Negative-input select, 2 bits per channel |
| ch_pos_sel | output | 4 | Positive-input select, 2 bits per channel |
| ch_edge_pol | output | 4 | Edge polarity, 2 bits per channel |
| ch_out_sel | output | 2 | Filtered/unfiltered output select |
| ch_filt_sel | output | 6 | Filter length code, 3 bits per channel |
| ch_wake_en | output | 2 | Wake-up enable |
| ch_win_latch | output | 2 | Window latch enable |
| ch_win_mode | output | 2 | Window compare mode |
| ref_level | output | 4 | Reference level setting |
| ref_src | output | 1 | Reference source select |
| cal_trig | output | 2 | Calibration trigger |
| cal_clk_sel | output | 4 | Calibration clock select, 2 bits per channel |
| cal_rev | output | 2 | Calibration reverse bits |
| irq | output | 2 | Per-channel interrupt request |
| wake_irq | output | 2 | Per-channel wake-up request |

## Verification
The assertions check the following on every cycle:
- a flag rises after a qualified event;
- a flag falls after a clearing write with no competing set;
- a flag or register holds when nothing touches it;
- a register captures its masked write data;
- reserved control bits and unmapped offsets read 0;
- the window bit never appears unless channel 0 reads high and channel 1 reads low.

Only the directed scenarios can show the rest:
- the exact field layout on the exported pins;
- the set-over-clear priority in a specific cycle;
- the wake-up gating by both enables;
- that a write to the calibration status offset leaves every register unchanged.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;

  localparam int NCH  = 2;
  localparam int DW   = 32;

  // word index of each implemented location (byte offset / 4)
  typedef enum logic [2:0] {
    RI_CTL0 = 3'd0,
    RI_CTL1 = 3'd1,
    RI_STAT = 3'd2,
    RI_REF  = 3'd3,
    RI_CALC = 3'd4,
    RI_CALS = 3'd5
  } reg_idx_e;

  localparam int NUM_REGS = 6;

  localparam logic [DW-1:0] CTL_MASK  = 32'h0007_F3FB;
  localparam logic [DW-1:0] REF_MASK  = 32'h0000_004F;
  localparam logic [DW-1:0] CALC_MASK = 32'h0003_00F3;

  // status word bit bases (channel index is added)
  localparam int ST_IFLAG = 0;
  localparam int ST_OUT   = 4;
  localparam int ST_WAKE  = 8;
  localparam int ST_STATE = 12;
  localparam int ST_WIN   = 16;

endpackage

// File: rtl/dcmp_masked_reg.sv
module dcmp_masked_reg #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata & MASK;
  end

  assert_reg_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q == ($past(wdata) & MASK)));

  assert_reg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/dcmp_flag.sv
module dcmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  // set has priority over a software clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(flag));

endmodule

// File: rtl/dcmp_status_view.sv
module dcmp_status_view
  import dcmp_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] cmp_out,
  input  logic [NCH-1:0] cmp_state,
  input  logic           win_sel,
  input  logic [NCH-1:0] int_flag,
  input  logic [NCH-1:0] wake_flag,
  output logic [DW-1:0]  word
);

  logic [NCH-1:0] out_vis;
  logic [NCH-1:0] state_vis;
  logic           win_in;

  assign out_vis   = cmp_out   & ch_en;
  assign state_vis = cmp_state & ch_en;
  assign win_in    = win_sel & out_vis[0] & ~out_vis[1];

  always_comb begin
    word = '0;
    for (int i = 0; i < NCH; i++) begin
      word[ST_IFLAG + i] = int_flag[i];
      word[ST_OUT   + i] = out_vis[i];
      word[ST_WAKE  + i] = wake_flag[i];
      word[ST_STATE + i] = state_vis[i];
    end
    word[ST_WIN] = win_in;
  end

  assert_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word[ST_WIN] |-> (word[ST_OUT] && !word[ST_OUT+1] && win_sel));

  assert_live_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en[0] |-> (!word[ST_OUT] && !word[ST_STATE]));

endmodule

// File: rtl/dcmp_csr.sv
module dcmp_csr
  import dcmp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        cmp_out,
  input  logic [1:0]        cmp_state,
  input  logic [1:0]        edge_evt,
  input  logic [1:0]        wake_evt,
  input  logic [1:0]        cal_done,
  input  logic [1:0]        cal_neg,
  input  logic [1:0]        cal_pos,
  output logic [1:0]        ch_enable,
  output logic [1:0]        ch_irq_en,
  output logic [1:0]        ch_invert,
  output logic [3:0]        ch_neg_sel,
  output logic [3:0]        ch_pos_sel,
  output logic [3:0]        ch_edge_pol,
  output logic [1:0]        ch_out_sel,
  output logic [5:0]        ch_filt_sel,
  output logic [1:0]        ch_wake_en,
  output logic [1:0]        ch_win_latch,
  output logic [1:0]        ch_win_mode,
  output logic [3:0]        ref_level,
  output logic              ref_src,
  output logic [1:0]        cal_trig,
  output logic [3:0]        cal_clk_sel,
  output logic [1:0]        cal_rev,
  output logic [1:0]        irq,
  output logic [1:0]        wake_irq
);

  localparam int IW = ADDR_W - 2;

  // ---------------- address decode ----------------
  logic [IW-1:0] widx;
  logic          addr_ok;
  reg_idx_e      ridx;
  logic          wr_hit;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign addr_ok = (bus_addr[1:0] == 2'b00) && (widx < IW'(NUM_REGS));
  assign ridx    = reg_idx_e'(widx[2:0]);
  assign wr_hit  = bus_sel && bus_wr && addr_ok;

  logic wr_stat, wr_ref, wr_calc;
  assign wr_stat = wr_hit && (ridx == RI_STAT);
  assign wr_ref  = wr_hit && (ridx == RI_REF);
  assign wr_calc = wr_hit && (ridx == RI_CALC);

  // ---------------- per-channel control and flags ----------------
  logic [DW-1:0]  ctl_q [NCH];
  logic [NCH-1:0] int_flag;
  logic [NCH-1:0] wake_flag;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic we_ctl;
    assign we_ctl = wr_hit && (ridx == reg_idx_e'(i));

    dcmp_masked_reg #(.W(DW), .MASK(CTL_MASK)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (we_ctl),
      .wdata (bus_wdata),
      .q     (ctl_q[i])
    );

    assign ch_enable[i]        = ctl_q[i][0];
    assign ch_irq_en[i]        = ctl_q[i][1];
    assign ch_invert[i]        = ctl_q[i][3];
    assign ch_neg_sel[2*i +: 2]  = ctl_q[i][5:4];
    assign ch_pos_sel[2*i +: 2]  = ctl_q[i][7:6];
    assign ch_edge_pol[2*i +: 2] = ctl_q[i][9:8];
    assign ch_out_sel[i]       = ctl_q[i][12];
    assign ch_filt_sel[3*i +: 3] = ctl_q[i][15:13];
    assign ch_wake_en[i]       = ctl_q[i][16];
    assign ch_win_latch[i]     = ctl_q[i][17];
    assign ch_win_mode[i]      = ctl_q[i][18];

    dcmp_flag u_iflag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (edge_evt[i] && ctl_q[i][0]),
      .clr   (wr_stat && bus_wdata[ST_IFLAG + i]),
      .flag  (int_flag[i])
    );

    dcmp_flag u_wflag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (wake_evt[i] && ctl_q[i][0] && ctl_q[i][16]),
      .clr   (wr_stat && bus_wdata[ST_WAKE + i]),
      .flag  (wake_flag[i])
    );

    assign irq[i]      = int_flag[i]  && ctl_q[i][1];
    assign wake_irq[i] = wake_flag[i] && ctl_q[i][1];
  end

  // ---------------- shared words ----------------
  logic [DW-1:0] ref_q;
  logic [DW-1:0] calc_q;
  logic [DW-1:0] stat_word;
  logic [DW-1:0] cals_word;

  dcmp_masked_reg #(.W(DW), .MASK(REF_MASK)) u_ref (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_ref), .wdata (bus_wdata), .q (ref_q)
  );

  dcmp_masked_reg #(.W(DW), .MASK(CALC_MASK)) u_calc (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_calc), .wdata (bus_wdata), .q (calc_q)
  );

  assign ref_level   = ref_q[3:0];
  assign ref_src     = ref_q[6];
  assign cal_trig    = calc_q[1:0];
  assign cal_clk_sel = calc_q[7:4];
  assign cal_rev     = calc_q[17:16];

  dcmp_status_view u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_en     (ch_enable),
    .cmp_out   (cmp_out),
    .cmp_state (cmp_state),
    .win_sel   (ctl_q[0][18]),
    .int_flag  (int_flag),
    .wake_flag (wake_flag),
    .word      (stat_word)
  );

  always_comb begin
    cals_word = '0;
    for (int i = 0; i < NCH; i++) begin
      cals_word[4*i]     = cal_done[i];
      cals_word[4*i + 1] = cal_neg[i];
      cals_word[4*i + 2] = cal_pos[i];
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (addr_ok) begin
      case (ridx)
        RI_CTL0: bus_rdata = ctl_q[0];
        RI_CTL1: bus_rdata = ctl_q[1];
        RI_STAT: bus_rdata = stat_word;
        RI_REF:  bus_rdata = ref_q;
        RI_CALC: bus_rdata = calc_q;
        RI_CALS: bus_rdata = cals_word;
        default: bus_rdata = '0;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok |-> (bus_rdata == '0));

  assert_ctl_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ok && (ridx == RI_CTL0 || ridx == RI_CTL1)) |-> ((bus_rdata & ~CTL_MASK) == '0));

  assert_cals_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ok && ridx == RI_CALS) |-> ((bus_rdata & 32'hFFFF_FF88) == '0));

endmodule

// File: tb/dcmp_csr_test.sv
module dcmp_csr_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  cmp_out = '0, cmp_state = '0, edge_evt = '0, wake_evt = '0;
  logic [1:0]  cal_done = '0, cal_neg = '0, cal_pos = '0;
  logic [1:0]  ch_enable, ch_irq_en, ch_invert, ch_out_sel, ch_wake_en, ch_win_latch, ch_win_mode;
  logic [3:0]  ch_neg_sel, ch_pos_sel, ch_edge_pol, ref_level, cal_clk_sel;
  logic [5:0]  ch_filt_sel;
  logic        ref_src;
  logic [1:0]  cal_trig, cal_rev, irq, wake_irq;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  dcmp_csr uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_out(cmp_out), .cmp_state(cmp_state),
    .edge_evt(edge_evt), .wake_evt(wake_evt), .cal_done(cal_done), .cal_neg(cal_neg),
    .cal_pos(cal_pos), .ch_enable(ch_enable), .ch_irq_en(ch_irq_en), .ch_invert(ch_invert),
    .ch_neg_sel(ch_neg_sel), .ch_pos_sel(ch_pos_sel), .ch_edge_pol(ch_edge_pol),
    .ch_out_sel(ch_out_sel), .ch_filt_sel(ch_filt_sel), .ch_wake_en(ch_wake_en),
    .ch_win_latch(ch_win_latch), .ch_win_mode(ch_win_mode), .ref_level(ref_level),
    .ref_src(ref_src), .cal_trig(cal_trig), .cal_clk_sel(cal_clk_sel), .cal_rev(cal_rev),
    .irq(irq), .wake_irq(wake_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse_edge(input logic [1:0] m);
    @(negedge clk); edge_evt = m;
    @(negedge clk); edge_evt = '0;
  endtask

  task automatic pulse_wake(input logic [1:0] m);
    @(negedge clk); wake_evt = m;
    @(negedge clk); wake_evt = '0;
  endtask

  task automatic t_reset;
    for (int k = 0; k < 6; k++) rdchk("R4 reset read", 5'(k*4), 32'h0);
    chk("R4 reset outputs", {31'b0, |{ch_enable, ch_irq_en, ch_invert, ch_neg_sel, ch_pos_sel,
        ch_edge_pol, ch_out_sel, ch_filt_sel, ch_wake_en, ch_win_latch, ch_win_mode, ref_level,
        ref_src, cal_trig, cal_clk_sel, cal_rev, irq, wake_irq}}, 32'h0);
  endtask

  task automatic t_ctrl_fields;
    wr(5'h00, 32'hFFFF_FFFF);
    rdchk("R3 ctl0 reserved masked", 5'h00, 32'h0007_F3FB);
    chk("R2 ch0 filter all ones", {29'b0, ch_filt_sel[2:0]}, 32'h7);
    wr(5'h04, 32'h0002_B26D);   // bit 2 reserved set on purpose
    rdchk("R3 ctl1 bit2 ignored", 5'h04, 32'h0002_B269);
    chk("R2 ch1 enable/ie/inv", {29'b0, ch_enable[1], ch_irq_en[1], ch_invert[1]}, 32'h5);
    chk("R2 ch1 neg/pos/pol", {26'b0, ch_neg_sel[3:2], ch_pos_sel[3:2], ch_edge_pol[3:2]}, 32'h26);
    chk("R2 ch1 outsel/filt", {28'b0, ch_out_sel[1], ch_filt_sel[5:3]}, 32'hD);
    chk("R2 ch1 wake/latch/win", {29'b0, ch_wake_en[1], ch_win_latch[1], ch_win_mode[1]}, 32'h2);
    wr(5'h00, 32'h0); wr(5'h04, 32'h0);
    rdchk("R2 ctl0 cleared", 5'h00, 32'h0);
  endtask

  task automatic t_int_flags;
    wr(5'h00, 32'h3);           // ch0 enabled with interrupt enable, ch1 disabled
    pulse_edge(2'b11);
    rdchk("R5 flag only on enabled channel", 5'h08, 32'h1);
    chk("R5 irq", {30'b0, irq}, 32'h1);
    wr(5'h08, 32'h2);
    rdchk("R6 zero bit leaves flag", 5'h08, 32'h1);
    wr(5'h08, 32'h1);
    rdchk("R6 write-1 clears", 5'h08, 32'h0);
    chk("R6 irq dropped", {30'b0, irq}, 32'h0);
    // set and clear in the same cycle: set wins
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h1; edge_evt = 2'b01;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; edge_evt = '0;
    rdchk("R6 set wins over clear", 5'h08, 32'h1);
    wr(5'h08, 32'h1);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_wake;
    wr(5'h00, 32'h0000_0001);   // ch0 enabled, no wake enable
    wr(5'h04, 32'h0001_0001);   // ch1 enabled with wake enable
    pulse_wake(2'b11);
    rdchk("R7 wake flag gated", 5'h08, 32'h200);
    chk("R7 wake_irq needs ie", {30'b0, wake_irq}, 32'h0);
    wr(5'h04, 32'h0001_0003);
    chk("R7 wake_irq with ie", {30'b0, wake_irq}, 32'h2);
    wr(5'h08, 32'h200);
    rdchk("R7 wake flag cleared", 5'h08, 32'h0);
    wr(5'h00, 32'h0); wr(5'h04, 32'h0);
  endtask

  task automatic t_live;
    cmp_out = 2'b11; cmp_state = 2'b11;
    rdchk("R8 both disabled", 5'h08, 32'h0);
    wr(5'h00, 32'h1);
    rdchk("R8 ch0 only", 5'h08, 32'h1010);
    wr(5'h04, 32'h1);
    rdchk("R8 both enabled", 5'h08, 32'h3030);
    wr(5'h08, 32'hFFFF_FFFF);
    rdchk("R8 read-only bits unaffected by write", 5'h08, 32'h3030);
    wr(5'h00, 32'h0);
    rdchk("R8 ch1 only", 5'h08, 32'h2020);
    cmp_out = '0; cmp_state = '0;
    wr(5'h04, 32'h0);
  endtask

  task automatic t_window;
    wr(5'h00, 32'h0004_0001);
    wr(5'h04, 32'h1);
    cmp_out = 2'b01;
    rdchk("R9 inside window", 5'h08, 32'h1_0010);
    cmp_out = 2'b11;
    rdchk("R9 both high outside", 5'h08, 32'h30);
    cmp_out = 2'b01;
    wr(5'h04, 32'h0);
    rdchk("R9 ch1 disabled reads low", 5'h08, 32'h1_0010);
    wr(5'h00, 32'h1);
    rdchk("R9 mode off", 5'h08, 32'h10);
    cmp_out = '0;
    wr(5'h00, 32'h0);
  endtask

  task automatic t_ref_cal;
    wr(5'h0C, 32'hFFFF_FFFF);
    rdchk("R10 ref mask", 5'h0C, 32'h4F);
    chk("R10 ref pins", {27'b0, ref_src, ref_level}, 32'h1F);
    wr(5'h10, 32'hFFFF_FFFF);
    rdchk("R11 calctl mask", 5'h10, 32'h0003_00F3);
    chk("R11 cal pins", {24'b0, cal_rev, cal_clk_sel, cal_trig}, 32'hFF);
    wr(5'h10, 32'h0001_0061);
    chk("R11 cal fields", {24'b0, cal_rev, cal_clk_sel, cal_trig}, 32'h59);
    cal_done = 2'b01; cal_neg = 2'b10; cal_pos = 2'b01;
    rdchk("R12 cal status layout", 5'h14, 32'h25);
    wr(5'h14, 32'hFFFF_FFFF);
    rdchk("R12 cal status write ignored", 5'h14, 32'h25);
    rdchk("R12 ref untouched", 5'h0C, 32'h4F);
  endtask

  task automatic t_unmapped;
    wr(5'h01, 32'hFFFF_FFFF);
    rdchk("R1 misaligned write ignored", 5'h00, 32'h0);
    rdchk("R1 misaligned read zero", 5'h0D, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    rdchk("R1 offset 0x18 reads zero", 5'h18, 32'h0);
    rdchk("R1 ctl1 untouched", 5'h04, 32'h0);
    rdchk("R1 calctl untouched", 5'h10, 32'h0001_0061);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_fields();
    t_int_flags();
    t_wake();
    t_live();
    t_window();
    t_ref_cal();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule